// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front-End

This block is the host-side register and interrupt core of a two-channel asynchronous serial controller. A byte-wide memory-mapped bus reaches each channel through two addresses, a control port and a data port. Behind the control port, each channel keeps sixteen write registers and sixteen read registers. They are reached indirectly: a first control write loads a register pointer, and the next control access uses it. The same first write can carry a command.

Each channel tracks a pending flag and an in-service flag for receive and for transmit. From these the block builds a shared interrupt vector and a single interrupt line. Received bytes arrive on a valid/ready port. Data-port writes produce a transmit strobe with the byte. A break-detect input raises a status bit. Bit timing, baud generation and line serialisation are handled elsewhere.

Top module: `dsc_regfront`

## Requirements
- R1: Address bit REG_SHIFT selects the port: 0 is control and 1 is data. Address bit REG_SHIFT+1 selects the channel: 1 is channel A and 0 is channel B. Each channel has its own registers.
- R2: A control write while the pointer is 0 loads the pointer from bits 2:0 and takes bits 5:3 as a command. Command 1 adds 8 to the loaded pointer. Any control write at a nonzero pointer stores the byte in that write register and sets the pointer back to 0. Write registers 12 and 13 read back at the same read index.
- R3: A control read returns the read register selected by the pointer on bus_rdata in the cycle after the strobe, then sets the pointer to 0. bus_rdata holds its value when no read occurs.
- R4: After reset:
  - status (read reg 0) is 0x44 and read reg 1 is 0x07;
  - the vector is 0x06;
  - irq is low and rx_ready is low;
  - the break interrupt enable (write reg 15 bit 7) is set.
- R5: rx_ready is high when write reg 3 bit 0 is set and receive-available (status bit 0) is clear. An accepted byte sets status bit 0 and a pending receive interrupt. A byte offered while one is held is ignored. A data-port read returns the held byte and clears status bit 0.
- R6: A data-port write pulses tx_strobe for that channel, with the byte on tx_data, in the cycle after the write, but only if write reg 5 bit 3 is set. The write always makes a transmit interrupt pending.
- R7: irq is the OR over both channels of three terms:
  - write reg 1 bit 1 and transmit pending;
  - write reg 1 bits 4:3 equal to 01 or 10, and receive pending;
  - write reg 15 bit 7 and the break bit.
- R8: Channel B read reg 2 returns the vector, chosen by the highest in-service condition in this order: receive A, transmit A, receive B, transmit B, none. With shared write reg 9 bit 4 clear the codes are 0x0C, 0x08, 0x04, 0x00, 0x06. With it set they are 0x30, 0x10, 0x20, 0x00, 0x60. Channel A read reg 2 returns 0.
- R9: A transmit interrupt enters service only when no receive interrupt of that channel is in service. Ending receive service through a data read re-raises a pending transmit. Clearing transmit (command 5) puts a pending receive back in service.
- R10: Command 5 clears the channel's transmit pending and in-service flags. Command 7 ends receive service if it is set, and then re-raises a pending transmit. Otherwise command 7 ends transmit service. Pending flags are kept.
- R11: A write to register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both.
  - After such a reset command the writing channel's pointer is not updated.
  - With bits 7:6 = 00 the byte is stored in the shared register 9.
  - Any reset command returns register 9 to 0xC0.
- R12: A pulse on brk_in sets status bit 7. The bit stays set until a reset of that channel.
- R13: Channel A read reg 3 shows pending flags:
  - bit 5 for receive A and bit 2 for receive B;
  - bit 4 for transmit A and bit 1 for transmit B, each only while that channel's write reg 1 bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| rx_valid | input | 2 | Received byte offered, index 1 = A, 0 = B |
| rx_data | input | 16 | Received bytes, 8 bits per channel |
| rx_ready | output | 2 | Channel can take a byte |
| brk_in | input | 2 | Break detected pulse per channel |
| tx_strobe | output | 2 | Byte to transmit, one-cycle pulse |
| tx_data | output | 16 | Transmit bytes, 8 bits per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench works through the interrupt service handshake in orderings where an early answer would show: a transmit raised while a receive is in service, command 7 issued with and without receive in service, and command 5 issued while a receive is still pending. A design that takes transmit into service too early, or that drops a pending flag on command 7, reads back the wrong vector code. It also checks cross-channel priority between receive B and transmit A in both vector forms. A reset written on one channel must leave that channel's pointer parked at 9; a design that clears it returns the status byte instead of 0x00 on the next read. A second byte offered while one is held must not replace the first.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int REG_CNT = 16;
   localparam int PTR_W   = 4;
   localparam int BYTE_W  = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   localparam logic [2:0] CMD_HIGH    = 3'd1;
   localparam logic [2:0] CMD_CLR_TX  = 3'd5;
   localparam logic [2:0] CMD_END_SVC = 3'd7;

   localparam byte_t MCTL_RESET = 8'hC0;
   localparam byte_t SPEC_VAL   = 8'h07;

   typedef struct packed {
      logic rx_pend;
      logic tx_pend;
      logic rx_svc;
      logic tx_svc;
   } irq_st_t;

   function automatic byte_t wreg_reset(input int idx);
      case (idx)
         4:       return 8'h04;
         9:       return MCTL_RESET;
         11:      return 8'h08;
         14:      return 8'h30;
         15:      return 8'hF8;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/dsc_vec.sv
module dsc_vec
   import dsc_pkg::*;
(
   input  logic    status_hi,
   input  irq_st_t st_a,
   input  irq_st_t st_b,
   output byte_t   vec_o
);
   always_comb begin
      if (st_a.rx_svc)      vec_o = status_hi ? 8'h30 : 8'h0C;
      else if (st_a.tx_svc) vec_o = status_hi ? 8'h10 : 8'h08;
      else if (st_b.rx_svc) vec_o = status_hi ? 8'h20 : 8'h04;
      else if (st_b.tx_svc) vec_o = 8'h00;
      else                  vec_o = status_hi ? 8'h60 : 8'h06;
   end
endmodule

// File: rtl/dsc_chan.sv
module dsc_chan
   import dsc_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             chan_rst,
   input  logic             wr_ctl,
   input  logic             wr_dat,
   input  logic             rd_ctl,
   input  logic             rd_dat,
   input  byte_t            wdata,
   input  logic             rx_valid,
   input  byte_t            rx_data,
   output logic             rx_ready,
   input  logic             brk_in,
   output logic [PTR_W-1:0] ptr_o,
   output byte_t            ctl_rd_o,
   output byte_t            rx_byte_o,
   output irq_st_t          st_o,
   output logic             tx_ien_o,
   output logic             irq_o,
   output logic             wr9_o,
   output logic             tx_strobe_o,
   output byte_t            tx_data_o
);
   byte_t            wreg [REG_CNT];
   logic [PTR_W-1:0] ptr;
   logic             avail, brk;
   byte_t            rx_byte;
   irq_st_t          st, st_n;
   logic             accept, at_zero, rst_cmd;
   logic [2:0]       cmd;
   logic [1:0]       rx_mode;

   assign cmd      = wdata[5:3];
   assign at_zero  = (ptr == '0);
   assign rx_ready = wreg[3][0] & ~avail;
   assign accept   = rx_valid & rx_ready;
   assign rst_cmd  = (wdata[7:6] != 2'b00);
   assign rx_mode  = wreg[1][4:3];

   always_comb begin
      st_n = st;
      if (wr_ctl && at_zero && cmd == CMD_CLR_TX) begin
         st_n.tx_pend = 1'b0;
         st_n.tx_svc  = 1'b0;
         if (st_n.rx_pend) st_n.rx_svc = 1'b1;
      end
      if (wr_ctl && at_zero && cmd == CMD_END_SVC) begin
         if (st_n.rx_svc) begin
            st_n.rx_svc = 1'b0;
            if (st_n.tx_pend) st_n.tx_svc = 1'b1;
         end else begin
            st_n.tx_svc = 1'b0;
         end
      end
      if (rd_dat) begin
         st_n.rx_pend = 1'b0;
         st_n.rx_svc  = 1'b0;
         if (st_n.tx_pend) st_n.tx_svc = 1'b1;
      end
      if (wr_dat) begin
         st_n.tx_pend = 1'b1;
         if (!st_n.rx_svc) st_n.tx_svc = 1'b1;
      end
      if (accept) begin
         st_n.rx_pend = 1'b1;
         st_n.rx_svc  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      tx_strobe_o <= 1'b0;
      if (rst || chan_rst) begin
         for (int i = 0; i < REG_CNT; i++) wreg[i] <= wreg_reset(i);
         ptr       <= '0;
         avail     <= 1'b0;
         brk       <= 1'b0;
         rx_byte   <= '0;
         st        <= '0;
         tx_data_o <= '0;
      end else begin
         st <= st_n;
         if (wr_ctl) begin
            if (at_zero) begin
               ptr <= {cmd == CMD_HIGH, wdata[2:0]};
            end else begin
               if (ptr != PTR_W'(9)) wreg[ptr] <= wdata;
               if (!(ptr == PTR_W'(9) && rst_cmd)) ptr <= '0;
            end
         end
         if (rd_ctl) ptr <= '0;
         if (wr_dat) begin
            tx_data_o   <= wdata;
            tx_strobe_o <= wreg[5][3];
         end
         if (accept) begin
            rx_byte <= rx_data;
            avail   <= 1'b1;
         end else if (rd_dat) begin
            avail <= 1'b0;
         end
         if (brk_in) brk <= 1'b1;
      end
   end

   always_comb begin
      case (ptr)
         4'd0:    ctl_rd_o = {brk, 1'b1, 3'b000, 1'b1, 1'b0, avail};
         4'd1:    ctl_rd_o = SPEC_VAL;
         4'd12:   ctl_rd_o = wreg[12];
         4'd13:   ctl_rd_o = wreg[13];
         default: ctl_rd_o = '0;
      endcase
   end

   assign ptr_o     = ptr;
   assign rx_byte_o = rx_byte;
   assign st_o      = st;
   assign tx_ien_o  = wreg[1][1];
   assign wr9_o     = wr_ctl && (ptr == PTR_W'(9));
   assign irq_o     = (wreg[1][1] & st.tx_pend)
                    | (((rx_mode == 2'b01) || (rx_mode == 2'b10)) & st.rx_pend)
                    | (wreg[15][7] & brk);

   // R5
   rx_take_chk: assert property (@(posedge clk) disable iff (rst)
      (accept && !chan_rst) |=> !rx_ready);
   // R5
   rx_drain_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_dat && !accept && !chan_rst) |=> !avail);
   // R3
   ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ctl && !chan_rst) |=> (ptr == '0));
   // R9
   tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(st.tx_svc) |-> (!$past(st.rx_svc) || !st.rx_svc));
   // R11
   chan_rst_chk: assert property (@(posedge clk) disable iff (rst)
      chan_rst |=> (ptr == '0 && !avail && !brk && !irq_o));
endmodule

// File: rtl/dsc_regfront.sv
module dsc_regfront
   import dsc_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int REG_SHIFT = 1,
   parameter int NCH       = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [NCH-1:0]    rx_valid,
   input  logic [NCH*8-1:0]  rx_data,
   output logic [NCH-1:0]    rx_ready,
   input  logic [NCH-1:0]    brk_in,
   output logic [NCH-1:0]    tx_strobe,
   output logic [NCH*8-1:0]  tx_data,
   output logic              irq
);
   localparam int SEL_BIT = REG_SHIFT;
   localparam int CH_BIT  = REG_SHIFT + 1;
   localparam int CH_A    = 1;
   localparam int CH_B    = 0;

   if (CH_BIT >= ADDR_W) begin : g_bad_addr
      $error("dsc_regfront: ADDR_W too small for REG_SHIFT");
   end
   if (NCH != 2) begin : g_bad_nch
      $error("dsc_regfront: exactly two channels supported");
   end

   logic             is_dat, ch_sel, rd_any;
   logic [NCH-1:0]   wr_ctl, wr_dat, rd_ctl, rd_dat, chan_rst, wr9, irq_t, tx_ien;
   logic [PTR_W-1:0] ptr   [NCH];
   byte_t            ctl_rd[NCH];
   byte_t            rx_b  [NCH];
   irq_st_t          st    [NCH];
   byte_t            mctl, vec, pend_byte, rd_val;
   logic             any_wr9;

   assign is_dat = bus_addr[SEL_BIT];
   assign ch_sel = bus_addr[CH_BIT];
   assign rd_any = bus_sel & ~bus_wr;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign wr_ctl[g] = bus_sel &  bus_wr & ~is_dat & (ch_sel == g[0]);
      assign wr_dat[g] = bus_sel &  bus_wr &  is_dat & (ch_sel == g[0]);
      assign rd_ctl[g] = rd_any & ~is_dat & (ch_sel == g[0]);
      assign rd_dat[g] = rd_any &  is_dat & (ch_sel == g[0]);
      assign chan_rst[g] = any_wr9 & bus_wdata[6 + g];

      dsc_chan u_ch (
         .clk        (clk),
         .rst        (rst),
         .chan_rst   (chan_rst[g]),
         .wr_ctl     (wr_ctl[g]),
         .wr_dat     (wr_dat[g]),
         .rd_ctl     (rd_ctl[g]),
         .rd_dat     (rd_dat[g]),
         .wdata      (bus_wdata),
         .rx_valid   (rx_valid[g]),
         .rx_data    (rx_data[g*8 +: 8]),
         .rx_ready   (rx_ready[g]),
         .brk_in     (brk_in[g]),
         .ptr_o      (ptr[g]),
         .ctl_rd_o   (ctl_rd[g]),
         .rx_byte_o  (rx_b[g]),
         .st_o       (st[g]),
         .tx_ien_o   (tx_ien[g]),
         .irq_o      (irq_t[g]),
         .wr9_o      (wr9[g]),
         .tx_strobe_o(tx_strobe[g]),
         .tx_data_o  (tx_data[g*8 +: 8])
      );
   end

   assign any_wr9 = |wr9;

   always_ff @(posedge clk) begin
      if (rst) begin
         mctl <= MCTL_RESET;
      end else if (any_wr9) begin
         mctl <= (bus_wdata[7:6] != 2'b00) ? MCTL_RESET : bus_wdata;
      end
   end

   dsc_vec u_vec (
      .status_hi(mctl[4]),
      .st_a     (st[CH_A]),
      .st_b     (st[CH_B]),
      .vec_o    (vec)
   );

   assign pend_byte = {2'b00, st[CH_A].rx_pend, st[CH_A].tx_pend & tx_ien[CH_A], 1'b0,
                       st[CH_B].rx_pend, st[CH_B].tx_pend & tx_ien[CH_B], 1'b0};

   always_comb begin
      if (is_dat) begin
         rd_val = rx_b[ch_sel];
      end else begin
         case (ptr[ch_sel])
            4'd2:    rd_val = (ch_sel == 1'b0) ? vec : 8'h00;
            4'd3:    rd_val = (ch_sel == 1'b1) ? pend_byte : 8'h00;
            default: rd_val = ctl_rd[ch_sel];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         bus_rdata <= '0;
      else if (rd_any) bus_rdata <= rd_val;
   end

   assign irq = |irq_t;

   // R3
   rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_any |=> $stable(bus_rdata));
   // R11
   mctl_reset_chk: assert property (@(posedge clk) disable iff (rst)
      (any_wr9 && bus_wdata[7:6] != 2'b00) |=> (mctl == MCTL_RESET));
endmodule

// File: tb/dsc_regfront_tb_top.sv
module dsc_regfront_tb_top;
   localparam int AW = 4;
   localparam int SH = 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sel = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wd = '0;
   logic [7:0]    rdata;
   logic [1:0]    rx_valid = '0;
   logic [15:0]   rx_data = '0;
   logic [1:0]    rx_ready, brk = '0, tx_strobe;
   logic [15:0]   tx_data;
   logic          irq;

   int n_cmp = 0, n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 1'b0;

   always #10 clk = ~clk;

   dsc_regfront #(.ADDR_W(AW), .REG_SHIFT(SH), .NCH(2)) dut_i (
      .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wd), .bus_rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_ready(rx_ready), .brk_in(brk), .tx_strobe(tx_strobe), .tx_data(tx_data),
      .irq(irq));

   // monitor: reads issued at a posedge are compared at the next negedge
   always @(posedge clk) rd_seen <= sel & ~wr;
   always @(negedge clk) begin
      if (rd_seen) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected read actual=%h expected=none", rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (rdata !== e) begin
               n_bad++;
               $display("FAIL %s actual=%h expected=%h", t, rdata, e);
            end
         end
      end
   end

   task automatic chk(input string t, input logic [7:0] act, input logic [7:0] e);
      n_cmp++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", t, act, e);
      end
   endtask

   function automatic logic [AW-1:0] adr(input bit a, input bit d);
      return AW'({a, d}) << SH;
   endfunction

   task automatic bus(input bit we, input bit a, input bit d, input logic [7:0] v);
      @(negedge clk);
      sel = 1'b1; wr = we; addr = adr(a, d); wd = v;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic pset(input bit a, input int r);
      if (r >= 8)      bus(1, a, 0, 8'(r - 8) | 8'h08);
      else if (r != 0) bus(1, a, 0, 8'(r));
   endtask

   task automatic wreg(input bit a, input int r, input logic [7:0] v);
      pset(a, r);
      bus(1, a, 0, v);
   endtask

   task automatic rreg(input bit a, input int r, input logic [7:0] e, input string t);
      pset(a, r);
      exp_q.push_back(e); tag_q.push_back(t);
      bus(0, a, 0, 8'h00);
   endtask

   task automatic rbare(input bit a, input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      bus(0, a, 0, 8'h00);
   endtask

   task automatic rdat(input bit a, input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      bus(0, a, 1, 8'h00);
   endtask

   task automatic wdat(input bit a, input logic [7:0] v);
      bus(1, a, 1, v);
   endtask

   task automatic cmd(input bit a, input logic [2:0] c);
      bus(1, a, 0, {2'b00, c, 3'b000});
   endtask

   task automatic rx_push(input bit a, input logic [7:0] v);
      @(negedge clk);
      rx_valid[a] = 1'b1; rx_data[a*8 +: 8] = v;
      @(negedge clk);
      rx_valid[a] = 1'b0;
   endtask

   task automatic brk_pulse(input bit a);
      @(negedge clk); brk[a] = 1'b1;
      @(negedge clk); brk[a] = 1'b0;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   localparam bit A = 1'b1;
   localparam bit B = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // reset state
      chk("R4 irq after reset", {7'd0, irq}, 8'h00);
      chk("R4 rx_ready after reset", {6'd0, rx_ready}, 8'h00);
      rreg(B, 0, 8'h44, "R4 status B");
      rreg(A, 1, 8'h07, "R4 read reg 1 A");
      rreg(B, 2, 8'h06, "R4 vector low none");
      rreg(A, 2, 8'h00, "R8 channel A reg 2");
      rbare(A, 8'h44, "R3 pointer back to 0 after read");
      // pointer, command 1, channel separation
      bus(1, A, 0, 8'h0C);
      bus(1, A, 0, 8'h5A);
      rreg(A, 12, 8'h5A, "R2 reg 12 via command 1");
      rreg(B, 12, 8'h00, "R1 channel B reg 12 untouched");
      wreg(A, 13, 8'hC3);
      rreg(A, 13, 8'hC3, "R2 reg 13 readback");
      rbare(A, 8'h44, "R2 pointer 0 after write");

      // receive on B
      wreg(B, 3, 8'h01);
      chk("R5 rx_ready B enabled", {7'd0, rx_ready[B]}, 8'h01);
      wreg(B, 1, 8'h10);
      rx_push(B, 8'h3C);
      chk("R5 rx_ready B while held", {7'd0, rx_ready[B]}, 8'h00);
      chk("R7 irq on receive", {7'd0, irq}, 8'h01);
      rreg(B, 0, 8'h45, "R5 status B available");
      rreg(B, 2, 8'h04, "R8 vector rx B low");
      rreg(A, 3, 8'h04, "R13 pending rx B");
      rx_push(B, 8'h99);
      rdat(B, 8'h3C, "R5 first byte kept");
      chk("R7 irq after data read", {7'd0, irq}, 8'h00);
      rreg(B, 0, 8'h44, "R5 status B drained");
      rreg(B, 2, 8'h06, "R8 vector none low");

      // transmit on A
      wdat(A, 8'h11);
      chk("R6 no strobe when disabled", {6'd0, tx_strobe}, 8'h00);
      chk("R7 irq tx not enabled", {7'd0, irq}, 8'h00);
      rreg(B, 2, 8'h08, "R8 vector tx A low");
      cmd(A, 3'd5);
      rreg(B, 2, 8'h06, "R10 command 5 clears tx A");
      wreg(A, 5, 8'h08);
      wreg(A, 1, 8'h02);
      wdat(A, 8'hA5);
      chk("R6 strobe A", {6'd0, tx_strobe}, 8'h02);
      chk("R6 tx data A", tx_data[15:8], 8'hA5);
      chk("R7 irq tx enabled", {7'd0, irq}, 8'h01);
      rreg(A, 3, 8'h10, "R13 pending tx A");
      cmd(A, 3'd5);
      chk("R10 irq after command 5", {7'd0, irq}, 8'h00);

      // status-high form and service ordering on A
      wreg(A, 9, 8'h10);
      rreg(B, 2, 8'h60, "R11 reg 9 stored, R8 none high");
      wreg(A, 3, 8'h01);
      wreg(A, 1, 8'h12);
      rx_push(A, 8'h11);
      rreg(B, 2, 8'h30, "R8 vector rx A high");
      wdat(A, 8'h22);
      rreg(B, 2, 8'h30, "R9 tx held behind rx service");
      rdat(A, 8'h11, "R5 data A");
      rreg(B, 2, 8'h10, "R9 tx re-raised after data read");
      cmd(A, 3'd7);
      rreg(B, 2, 8'h60, "R10 command 7 ends tx service");
      chk("R10 tx still pending", {7'd0, irq}, 8'h01);
      cmd(A, 3'd5);
      chk("R10 irq after command 5", {7'd0, irq}, 8'h00);

      rx_push(A, 8'h33);
      wdat(A, 8'h44);
      cmd(A, 3'd7);
      rreg(B, 2, 8'h10, "R10 command 7 ends rx service, tx raised");
      rreg(A, 0, 8'h45, "R10 receive still pending");
      rdat(A, 8'h33, "R5 data A second");
      rreg(B, 2, 8'h10, "R9 tx stays in service");
      cmd(A, 3'd5);
      rreg(B, 2, 8'h60, "R10 cleared");

      rx_push(A, 8'h55);
      cmd(A, 3'd7);
      rreg(B, 2, 8'h60, "R10 command 7 with no tx pending");
      chk("R7 rx pending keeps irq", {7'd0, irq}, 8'h01);
      wdat(A, 8'h66);
      rreg(B, 2, 8'h10, "R9 tx enters service");
      cmd(A, 3'd5);
      rreg(B, 2, 8'h30, "R9 command 5 re-raises rx");
      rdat(A, 8'h55, "R5 data A third");
      rreg(B, 2, 8'h60, "R8 none high");
      chk("R7 irq idle", {7'd0, irq}, 8'h00);

      // cross-channel priority
      rx_push(B, 8'h77);
      rreg(B, 2, 8'h20, "R8 vector rx B high");
      wdat(A, 8'h01);
      rreg(B, 2, 8'h10, "R8 tx A above rx B");
      rreg(A, 3, 8'h14, "R13 pending tx A and rx B");
      cmd(A, 3'd5);
      rreg(B, 2, 8'h20, "R8 rx B after tx A cleared");
      rdat(B, 8'h77, "R5 data B");
      wdat(B, 8'h02);
      chk("R6 no strobe B disabled", {6'd0, tx_strobe}, 8'h00);
      rreg(B, 2, 8'h00, "R8 vector tx B");
      rreg(A, 3, 8'h00, "R13 tx B masked when not enabled");
      cmd(B, 3'd5);
      rreg(B, 2, 8'h60, "R10 tx B cleared");
      chk("R7 irq idle again", {7'd0, irq}, 8'h00);

      // break
      brk_pulse(A);
      rreg(A, 0, 8'hC4, "R12 break status A");
      chk("R12 break irq by default enable", {7'd0, irq}, 8'h01);
      wreg(A, 15, 8'h00);
      chk("R12 break irq disabled", {7'd0, irq}, 8'h00);
      rreg(A, 0, 8'hC4, "R12 break bit held");

      // channel reset commands
      bus(1, B, 0, 8'h09);
      bus(1, B, 0, 8'h80);
      rbare(B, 8'h00, "R11 writer pointer stays at 9");
      rreg(B, 2, 8'h06, "R11 reg 9 back to reset");
      rbare(A, 8'h44, "R11 channel A status reset");
      rreg(A, 12, 8'h00, "R11 channel A reg 12 reset");
      chk("R11 rx_ready after A reset", {6'd0, rx_ready}, 8'h01);
      bus(1, B, 0, 8'h09);
      bus(1, B, 0, 8'h40);
      chk("R11 rx_ready after B reset", {6'd0, rx_ready}, 8'h00);
      rbare(B, 8'h44, "R11 channel B pointer cleared by own reset");
      wreg(A, 3, 8'h01);
      wreg(B, 3, 8'h01);
      chk("R5 both ready", {6'd0, rx_ready}, 8'h03);
      bus(1, A, 0, 8'h09);
      bus(1, A, 0, 8'hC0);
      chk("R11 both reset", {6'd0, rx_ready}, 8'h00);

      repeat (3) @(negedge clk);
      chk("R3 all reads answered", 8'(exp_q.size()), 8'h00);
      summary();
      $finish;
   end
endmodule